// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core. Two sources are external active-low pins. Each pin can sense a level or a falling edge. Two sources are timer overflow pulses. The fifth is a serial-bus source, formed as the OR of three sticky status flags. The block holds the pending flags, a per-source enable register with a global enable bit, and a per-source priority register. It presents a registered request and a 3-bit vector index to the core.

The core answers a request with a vector-acknowledge strobe and ends the handler with a return strobe. On acknowledge, the block marks the level of the granted source as in service. Edge-sensed pins and timer flags clear on acknowledge. Level-sensed pins and the serial flags do not clear on acknowledge. Service nests over two levels. A low-level handler can be interrupted only by a high-level source, and a high-level handler cannot be interrupted.

Software reaches all state through a small register port. Writes to a flag act exactly like a hardware set or clear.

Top module: `irqCtrlTop`

## Requirements
- R1: After reset, `irqReq` is 0. With all pins held high, every register reads 0.
- R2: Vector indices are 0 for external 0, 1 for timer 0, 2 for external 1, 3 for timer 1 and 4 for the serial source. Within one level, the candidate first in the sequence external 0, serial, timer 0, external 1, timer 1 wins.
- R3: When enabled requests of both levels are present, a high-level source wins regardless of its position in that sequence.
- R4: In edge mode (type bit 1), a falling edge on an external pin sets its flag. A timer overflow pulse sets its flag. These four flags clear when their vector is acknowledged.
- R5: The serial source is pending while any of its three status flags (address 3, bits 2:0) is set. Acknowledge never clears these flags; only a register write does.
- R6: In level mode (type bit 0), an external flag follows the inverted pin every cycle. If the pin is still low after the return, the same vector is requested again.
- R7: A source requests only when its enable bit and the global enable (address 1, bit 7) are both 1. Enable bits sit at 0, 1, 2, 3 and 5 for vectors 0 to 4.
- R8: While a low-level service is active, only high-level sources may request. While a high-level service is active, nothing may request.
- R9: The `irqReq` output and `irqVec` output are registered. An acknowledge drops `irqReq` in the next cycle and marks the granted level in service. A return strobe clears the high in-service mark if it is set, and otherwise clears the low mark.
- R10: Address 0 holds these fields: bit 0 is the external 0 type and bit 1 its flag; bit 2 is the external 1 type and bit 3 its flag; bit 4 is the timer 0 flag and bit 5 the timer 1 flag. A write replaces the stored values, and a software write takes precedence over a hardware event in the same cycle. All registers read back through `regRdData`.
- R11: In the priority register (address 2), bit 5 maps vector 4 and bits 0 to 3 map vectors 0 to 3; a 1 in a bit means high level. Bits 7, 6 and 4 read 0 and ignore writes. In the enable register, bits 6 and 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPinN | input | 2 | External request pins, active low |
| timerOvf | input | 2 | Timer 0 / timer 1 overflow pulses |
| serStatusSet | input | 3 | Set pulses for the three serial status flags |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on `regAddr`) |
| vecAck | input | 1 | Vector call acknowledge |
| retStrobe | input | 1 | Return from interrupt |
| irqReq | output | 1 | Interrupt request to the core |
| irqVec | output | 3 | Vector index of the request |

## Verification
The hardest state to reach from the ports is two nested services. In that state a low-level handler has been preempted by a high-level one, and a further high-level flag is pending. Return strobes must then unwind the two levels in the right order. The bench drives flags and priorities through register writes and issues acknowledges only against the vector currently presented. It returns one level at a time and checks the request after each step. A sweep over every pending pattern and every priority pattern covers the in-level order and the level override.

// File: rtl/irqCtrlPkg.sv
package irqCtrlPkg;
  localparam int NUM_SRC = 5;
  localparam int VEC_W   = 3;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int NUM_EXT = 2;
  localparam int NUM_TMR = 2;
  localparam int NUM_SER = 3;

  localparam int VEC_EXT0 = 0;
  localparam int VEC_TMR0 = 1;
  localparam int VEC_EXT1 = 2;
  localparam int VEC_TMR1 = 3;
  localparam int VEC_SER  = 4;

  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PRIO  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SER   = 2'd3;

  localparam int GLOBAL_EN_BIT = 7;
  localparam logic [DATA_W-1:0] PRIO_VALID = 8'b0010_1111;
  localparam logic [DATA_W-1:0] EN_VALID   = 8'b1010_1111;

  // Per-source bit in the enable and priority registers.
  function automatic int srcBit(input int vec);
    return (vec == VEC_SER) ? 5 : vec;
  endfunction

  // In-level polling order, position 0 first.
  function automatic logic [VEC_W-1:0] pollAt(input int pos);
    case (pos)
      0: return VEC_W'(VEC_EXT0);
      1: return VEC_W'(VEC_SER);
      2: return VEC_W'(VEC_TMR0);
      3: return VEC_W'(VEC_EXT1);
      default: return VEC_W'(VEC_TMR1);
    endcase
  endfunction

  function automatic int extVec(input int idx);
    return (idx == 0) ? VEC_EXT0 : VEC_EXT1;
  endfunction

  function automatic int tmrVec(input int idx);
    return (idx == 0) ? VEC_TMR0 : VEC_TMR1;
  endfunction

  typedef struct packed {
    logic             ackValid;
    logic [VEC_W-1:0] ackVec;
  } ackStrobe_t;
endpackage

// File: rtl/irqCtrlRegs.sv
module irqCtrlRegs
  import irqCtrlPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EXT-1:0]    extPinN,
  input  logic [NUM_TMR-1:0]    timerOvf,
  input  logic [NUM_SER-1:0]    serStatusSet,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  ackStrobe_t            strobe,
  output logic [NUM_SRC-1:0]    pendVec,
  output logic [NUM_SRC-1:0]    enVec,
  output logic [NUM_SRC-1:0]    prioVec,
  output logic                  globalEn
);
  logic wrFlags, wrEn, wrPrio, wrSer;
  logic [NUM_EXT-1:0] extType, extFlag;
  logic [NUM_TMR-1:0] tmrFlag;
  logic [NUM_SER-1:0] serFlag;
  logic [DATA_W-1:0]  enReg, prioReg;

  assign wrFlags = regWrEn && (regAddr == ADDR_FLAGS);
  assign wrEn    = regWrEn && (regAddr == ADDR_EN);
  assign wrPrio  = regWrEn && (regAddr == ADDR_PRIO);
  assign wrSer   = regWrEn && (regAddr == ADDR_SER);

  // External pins: level or falling-edge sensing per type bit.
  for (genvar i = 0; i < NUM_EXT; i++) begin : gExt
    localparam int VEC = extVec(i);
    logic typeQ, flagQ, pinQ, ackHit;
    assign ackHit = strobe.ackValid && (strobe.ackVec == VEC_W'(VEC));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        typeQ <= 1'b0;
        flagQ <= 1'b0;
        pinQ  <= 1'b1;
      end else begin
        pinQ <= extPinN[i];
        if (wrFlags) typeQ <= regWrData[2*i];
        if (wrFlags)                      flagQ <= regWrData[2*i+1];
        else if (!typeQ)                  flagQ <= ~extPinN[i];
        else if (pinQ && !extPinN[i])     flagQ <= 1'b1;
        else if (ackHit)                  flagQ <= 1'b0;
      end
    end

    assign extType[i]   = typeQ;
    assign extFlag[i]   = flagQ;
    assign pendVec[VEC] = flagQ;

    AST_EDGE_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (ackHit && typeQ && !wrFlags && !(pinQ && !extPinN[i])) |=> !flagQ); // R4
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
      (!typeQ && !wrFlags) |=> (flagQ == !$past(extPinN[i]))); // R6
  end

  // Timer overflow flags: set by pulse, cleared on their vector call.
  for (genvar i = 0; i < NUM_TMR; i++) begin : gTmr
    localparam int VEC = tmrVec(i);
    localparam int WBIT = 4 + i;
    logic flagQ, ackHit;
    assign ackHit = strobe.ackValid && (strobe.ackVec == VEC_W'(VEC));

    always_ff @(posedge clk) begin
      if (!rstN)              flagQ <= 1'b0;
      else if (wrFlags)       flagQ <= regWrData[WBIT];
      else if (timerOvf[i])   flagQ <= 1'b1;
      else if (ackHit)        flagQ <= 1'b0;
    end

    assign tmrFlag[i]   = flagQ;
    assign pendVec[VEC] = flagQ;

    AST_TMR_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (ackHit && !wrFlags && !timerOvf[i]) |=> !flagQ); // R4
  end

  // Serial status flags: sticky until software clears them.
  always_ff @(posedge clk) begin
    if (!rstN)      serFlag <= '0;
    else if (wrSer) serFlag <= regWrData[NUM_SER-1:0];
    else            serFlag <= serFlag | serStatusSet;
  end
  assign pendVec[VEC_SER] = |serFlag;

  AST_SER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrSer |=> ((serFlag & $past(serFlag)) == $past(serFlag))); // R5

  // Enable and priority registers with reserved bits forced to zero.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      prioReg <= '0;
    end else begin
      if (wrEn)   enReg   <= regWrData & EN_VALID;
      if (wrPrio) prioReg <= regWrData & PRIO_VALID;
    end
  end

  for (genvar v = 0; v < NUM_SRC; v++) begin : gMap
    localparam int B = srcBit(v);
    assign enVec[v]   = enReg[B];
    assign prioVec[v] = prioReg[B];
  end
  assign globalEn = enReg[GLOBAL_EN_BIT];

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_FLAGS: regRdData = {2'b00, tmrFlag[1], tmrFlag[0],
                               extFlag[1], extType[1], extFlag[0], extType[0]};
      ADDR_EN:    regRdData = enReg;
      ADDR_PRIO:  regRdData = prioReg;
      default:    regRdData = {{(DATA_W-NUM_SER){1'b0}}, serFlag};
    endcase
  end
endmodule

// File: rtl/irqCtrlArb.sv
module irqCtrlArb
  import irqCtrlPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic [NUM_SRC-1:0] enVec,
  input  logic [NUM_SRC-1:0] prioVec,
  input  logic               globalEn,
  input  logic               vecAck,
  input  logic               retStrobe,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output ackStrobe_t         strobe
);
  logic               inSvcHi, inSvcLo, reqLvl;
  logic [NUM_SRC-1:0] live, hiCand, loCand;
  logic               allowHi, allowLo, found, pickLvl;
  logic [VEC_W-1:0]   pickVec;

  assign strobe.ackValid = vecAck && irqReq;
  assign strobe.ackVec   = irqVec;

  assign live    = pendVec & enVec & {NUM_SRC{globalEn}};
  assign hiCand  = live & prioVec;
  assign loCand  = live & ~prioVec;
  assign allowHi = !inSvcHi;
  assign allowLo = !inSvcHi && !inSvcLo;

  // High level first, then low; each walked in polling order.
  always_comb begin
    found   = 1'b0;
    pickVec = '0;
    pickLvl = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (!found && allowHi && hiCand[pollAt(k)]) begin
        found   = 1'b1;
        pickVec = pollAt(k);
        pickLvl = 1'b1;
      end
    end
    for (int k = 0; k < NUM_SRC; k++) begin
      if (!found && allowLo && loCand[pollAt(k)]) begin
        found   = 1'b1;
        pickVec = pollAt(k);
        pickLvl = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      irqVec <= '0;
      reqLvl <= 1'b0;
    end else begin
      irqReq <= found && !strobe.ackValid;
      irqVec <= pickVec;
      reqLvl <= pickLvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSvcHi <= 1'b0;
      inSvcLo <= 1'b0;
    end else if (strobe.ackValid) begin
      if (reqLvl) inSvcHi <= 1'b1;
      else        inSvcLo <= 1'b1;
    end else if (retStrobe) begin
      if (inSvcHi) inSvcHi <= 1'b0;
      else         inSvcLo <= 1'b0;
    end
  end

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVec < VEC_W'(NUM_SRC))); // R2
  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !irqReq); // R7
  AST_HI_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    inSvcHi |=> !irqReq); // R8
  AST_LO_BLOCKS_LO: assert property (@(posedge clk) disable iff (!rstN)
    inSvcLo |=> !(irqReq && !reqLvl)); // R8
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackValid |=> !irqReq); // R9
  AST_ACK_MARKS_LVL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackValid |=> ($past(reqLvl) ? inSvcHi : inSvcLo)); // R9
  AST_RET_HI_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !strobe.ackValid && inSvcHi) |=> (!inSvcHi && (inSvcLo == $past(inSvcLo)))); // R9
endmodule

// File: rtl/irqCtrlTop.sv
module irqCtrlTop
  import irqCtrlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        extPinN,
  input  logic [1:0]        timerOvf,
  input  logic [2:0]        serStatusSet,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              vecAck,
  input  logic              retStrobe,
  output logic              irqReq,
  output logic [2:0]        irqVec
);
  ackStrobe_t         strobe;
  logic [NUM_SRC-1:0] pendVec, enVec, prioVec;
  logic               globalEn;

  irqCtrlRegs u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .extPinN      (extPinN),
    .timerOvf     (timerOvf),
    .serStatusSet (serStatusSet),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .strobe       (strobe),
    .pendVec      (pendVec),
    .enVec        (enVec),
    .prioVec      (prioVec),
    .globalEn     (globalEn)
  );

  irqCtrlArb u_arb (
    .clk       (clk),
    .rstN      (rstN),
    .pendVec   (pendVec),
    .enVec     (enVec),
    .prioVec   (prioVec),
    .globalEn  (globalEn),
    .vecAck    (vecAck),
    .retStrobe (retStrobe),
    .irqReq    (irqReq),
    .irqVec    (irqVec),
    .strobe    (strobe)
  );
endmodule

// File: tb/irqCtrlTop_tb.sv
module irqCtrlTop_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] extPinN = 2'b11;
  logic [1:0] timerOvf = '0;
  logic [2:0] serStatusSet = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       vecAck = 1'b0;
  logic       retStrobe = 1'b0;
  logic       irqReq;
  logic [2:0] irqVec;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irqCtrlTop u_dut (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .timerOvf(timerOvf),
    .serStatusSet(serStatusSet), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .vecAck(vecAck),
    .retStrobe(retStrobe), .irqReq(irqReq), .irqVec(irqVec)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string rid, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rid, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [7:0] exp, input string rid);
    regAddr = a;
    #1;
    check(regRdData == exp, rid, "readback", int'(regRdData), int'(exp));
  endtask

  task automatic ack();
    vecAck = 1'b1;
    @(negedge clk);
    vecAck = 1'b0;
  endtask

  task automatic ret();
    retStrobe = 1'b1;
    @(negedge clk);
    retStrobe = 1'b0;
  endtask

  // expReq 0: only the request is compared; otherwise the vector as well.
  task automatic expIrq(input bit expReq, input int expVec, input string rid);
    if (!expReq)
      check(irqReq == 1'b0, rid, "irqReq", int'(irqReq), 0);
    else
      check(irqReq && (int'(irqVec) == expVec), rid, "req/vec",
            {28'd0, irqReq, irqVec}, 8 + expVec);
  endtask

  function automatic int predict(input logic [4:0] pend, input logic [4:0] prio);
    int ord [5] = '{0, 4, 1, 2, 3};
    logic [4:0] cand;
    cand = ((pend & prio) != 0) ? (pend & prio) : pend;
    for (int k = 0; k < 5; k++)
      if (cand[ord[k]]) return ord[k];
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1: reset state
    expIrq(0, 0, "R1");
    for (int a = 0; a < 4; a++) rdCheck(2'(a), 8'h00, "R1");

    // R11: reserved bits
    wr(2'd2, 8'hFF); rdCheck(2'd2, 8'h2F, "R11");
    wr(2'd1, 8'hFF); rdCheck(2'd1, 8'hAF, "R11");

    // R2 / R3 / R10: sweep every pending pattern under every priority pattern
    wr(2'd1, 8'hAF);
    for (int p = 0; p < 32; p++) begin
      logic [4:0] pr;
      pr = 5'(p);
      wr(2'd2, {2'b00, pr[4], 1'b0, pr[3:0]});
      for (int f = 0; f < 32; f++) begin
        logic [4:0] fv;
        logic [7:0] fb;
        int ev;
        fv = 5'(f);
        fb = {2'b00, fv[3], fv[1], fv[2], 1'b1, fv[0], 1'b1};
        wr(2'd0, fb);
        wr(2'd3, {7'd0, fv[4]});
        tick(1);
        ev = predict(fv, pr);
        expIrq(ev >= 0, ev, (pr != 0 && (fv & pr) != 0 && (fv & ~pr) != 0) ? "R3" : "R2");
        if (p == 0) rdCheck(2'd0, fb, "R10");
      end
    end
    wr(2'd3, 8'h00);

    // R8 / R9 / R4: nesting with timer 1 at high level
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h07);
    tick(2); expIrq(1, 0, "R2");
    ack();   expIrq(0, 0, "R9");
    rdCheck(2'd0, 8'h05, "R4");
    wr(2'd0, 8'h2D);
    tick(2); expIrq(1, 3, "R8");
    ack();   rdCheck(2'd0, 8'h0D, "R4");
    wr(2'd0, 8'h2F);
    tick(2); expIrq(0, 0, "R8");
    ret();
    tick(2); expIrq(1, 3, "R9");
    wr(2'd0, 8'h0F);
    tick(2); expIrq(0, 0, "R8");
    ret();
    tick(2); expIrq(1, 0, "R9");
    wr(2'd0, 8'h05); ret(); ret(); tick(2);
    expIrq(0, 0, "R9");

    // R4: timer pulse and external falling edge
    wr(2'd2, 8'h00);
    timerOvf[0] = 1'b1; @(negedge clk); timerOvf[0] = 1'b0;
    tick(2); expIrq(1, 1, "R4");
    ack(); rdCheck(2'd0, 8'h05, "R4");
    ret(); tick(2); expIrq(0, 0, "R4");
    extPinN[1] = 1'b0;
    tick(3); expIrq(1, 2, "R4");
    ack(); ret(); tick(2);
    expIrq(0, 0, "R4");
    rdCheck(2'd0, 8'h05, "R4");
    extPinN[1] = 1'b1;
    tick(2);

    // R6: level mode on external 0
    wr(2'd0, 8'h04);
    extPinN[0] = 1'b0;
    tick(3); expIrq(1, 0, "R6");
    rdCheck(2'd0, 8'h06, "R6");
    ack(); expIrq(0, 0, "R6");
    ret(); tick(3); expIrq(1, 0, "R6");
    extPinN[0] = 1'b1;
    tick(3); expIrq(0, 0, "R6");
    rdCheck(2'd0, 8'h04, "R6");
    ret(); tick(2);

    // R7: enables
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h2F); tick(2); expIrq(0, 0, "R7");
    wr(2'd1, 8'hAE); tick(2); expIrq(0, 0, "R7");
    wr(2'd1, 8'h81); tick(2); expIrq(1, 0, "R7");
    wr(2'd1, 8'hAF); wr(2'd0, 8'h05); tick(2);

    // R5: serial source is sticky across acknowledge
    serStatusSet[1] = 1'b1; @(negedge clk); serStatusSet[1] = 1'b0;
    tick(2); expIrq(1, 4, "R5");
    rdCheck(2'd3, 8'h02, "R5");
    ack(); rdCheck(2'd3, 8'h02, "R5");
    tick(1); expIrq(0, 0, "R8");
    ret(); tick(2); expIrq(1, 4, "R5");
    wr(2'd3, 8'h00); tick(2); expIrq(0, 0, "R5");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule